// File: doc/BRIEF.md
# Sampling Converter Start/Read Sequencer

This block is the host-side master for an 8-bit parallel sampling converter that is controlled by one start strobe and reports progress on a BUSY line. A single-cycle trigger starts a transaction. The sequencer raises the start line and holds it for a set time. It then drops the line and waits for BUSY to rise and later to fall. After that it runs a chip-select and read cycle and captures the byte that the converter drives. The byte is presented on the output with a one-cycle valid pulse.

The converter's power behaviour depends only on the level of the start line when BUSY falls. In low-power mode the line is held high long enough for the converter to wake up, and is low while the conversion runs, so the converter sleeps afterwards. In fast mode the line is raised again as soon as BUSY is seen high, and it stays high through the end of conversion and into idle, so the converter stays awake.

The BUSY input passes through a synchroniser. A programmable cycle limit bounds each wait on BUSY. A guard timer keeps the next falling start edge a minimum time away from the end of the previous read.

Top module: `adch_host`

## Requirements
- R1: Every high phase of `cnv_start_o` lasts at least `START_W_CYC` clock cycles before the line falls.
- R2: With `pd_mode_i`=1 at the trigger, the start line is held high for at least `PWRUP_CYC` cycles, and it is low when BUSY falls.
- R3: With `pd_mode_i`=0 at the trigger, the start line is raised again once BUSY is seen high, is high when BUSY falls, and stays high in idle afterwards.
- R4: A read starts only after BUSY is low. `cs_n_o` goes low at least one cycle before `rd_n_o` goes low, and it is released at least one cycle after `rd_n_o` returns high. `rd_n_o` is never low while `cs_n_o` is high.
- R5: `rd_n_o` stays low for `RD_LOW_CYC` cycles. The byte on `rd_data_i` in the last low cycle appears on `data_o`, with `data_vld_o` high for exactly one cycle, in the cycle in which `rd_n_o` returns high.
- R6: A falling edge of the start line comes at least `GUARD_CYC` cycles after the most recent rising edge of `rd_n_o`.
- R7: A trigger that arrives while a transaction is in progress has no effect. It starts no extra conversion and yields no extra byte, and the `pd_mode_i` value sampled with it is not taken.
- R8: If BUSY is not seen high within `tmo_limit_i` cycles after the start line falls, `err_o` pulses for one cycle with the start line low, chip-select and read high, and the block returns to idle.
- R9: If BUSY is not seen low within `tmo_limit_i` cycles after it rose, `err_o` pulses with the start line driven low, and no byte is produced.
- R10: After reset, the start line is low, `cs_n_o` and `rd_n_o` are high, and `data_vld_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_i | input | 1 | Single-cycle request for one conversion |
| pd_mode_i | input | 1 | Power mode taken with the trigger: 1 = low-power, 0 = fast |
| tmo_limit_i | input | TMO_W | Cycle limit for each wait on BUSY |
| cnv_start_o | output | 1 | Start strobe to the converter |
| cnv_busy_i | input | 1 | BUSY from the converter (asynchronous) |
| cs_n_o | output | 1 | Chip select, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| rd_data_i | input | DATA_W | Converter data bus |
| data_o | output | DATA_W | Captured byte |
| data_vld_o | output | 1 | One-cycle pulse marking a new byte |
| err_o | output | 1 | One-cycle pulse on a BUSY timeout |

## Verification
The bench drives a behavioural converter. The converter starts an internal wake-up pulse on every rising edge of the start line and begins converting on the later of the falling edges of that pulse and the start line. It records the start level at each end of conversion, so a transaction in the wrong power mode shows up directly. Low-power transactions, back-to-back fast transactions with no idle gap, and mode changes in both directions separate correct mode handling from a line left in the wrong state. The zero-gap fast runs make the guard timer, not the pulse width, set the start fall. Triggers injected mid-transaction, a converter that never raises BUSY, and one that never drops it test the ignore path and both timeout paths. A later normal transaction shows that the block recovers after each timeout.

// File: rtl/adch_pkg.sv
package adch_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ARM,
    S_FIRE,
    S_CONV,
    S_SEL,
    S_READ,
    S_HOLD
  } seq_state_e;
endpackage

// File: rtl/adch_sync.sv
module adch_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/adch_timer.sv
module adch_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/adch_seq.sv
module adch_seq
  import adch_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int TMO_W       = 16,
  parameter int PH_W        = 6,
  parameter int GD_W        = 3,
  parameter int START_W_CYC = 2,
  parameter int PWRUP_CYC   = 50,
  parameter int RD_LOW_CYC  = 2,
  parameter int GUARD_CYC   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_i,
  input  logic              pd_mode_i,
  input  logic [TMO_W-1:0]  tmo_limit_i,
  input  logic              busy_s,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              ph_zero,
  input  logic              gd_zero,
  output logic              ph_load,
  output logic [PH_W-1:0]   ph_val,
  output logic              gd_load,
  output logic [GD_W-1:0]   gd_val,
  output logic              start_o,
  output logic              cs_n_o,
  output logic              rd_n_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_vld_o,
  output logic              err_o
);
  localparam logic [PH_W-1:0] PH_PWRUP = PH_W'(PWRUP_CYC - 1);
  localparam logic [PH_W-1:0] PH_START = PH_W'(START_W_CYC - 1);
  localparam logic [PH_W-1:0] PH_READ  = PH_W'(RD_LOW_CYC - 1);

  seq_state_e       st;
  logic             pd_q;
  logic [TMO_W-1:0] tmo_cnt;
  logic             tmo_hit;

  assign tmo_hit = (tmo_cnt >= tmo_limit_i);

  always_comb begin
    ph_load = 1'b0;
    ph_val  = PH_START;
    if (st == S_IDLE && trig_i) begin
      ph_load = 1'b1;
      ph_val  = pd_mode_i ? PH_PWRUP : PH_START;
    end else if (st == S_SEL) begin
      ph_load = 1'b1;
      ph_val  = PH_READ;
    end
  end

  assign gd_load = (st == S_READ) && ph_zero;
  assign gd_val  = GD_W'(GUARD_CYC - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      pd_q       <= 1'b0;
      tmo_cnt    <= '0;
      start_o    <= 1'b0;
      cs_n_o     <= 1'b1;
      rd_n_o     <= 1'b1;
      data_o     <= '0;
      data_vld_o <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      data_vld_o <= 1'b0;
      err_o      <= 1'b0;
      case (st)
        S_IDLE: begin
          if (trig_i) begin
            pd_q    <= pd_mode_i;
            start_o <= 1'b1;
            st      <= S_ARM;
          end
        end
        S_ARM: begin
          if (ph_zero && gd_zero) begin
            start_o <= 1'b0;
            tmo_cnt <= '0;
            st      <= S_FIRE;
          end
        end
        S_FIRE: begin
          if (busy_s) begin
            tmo_cnt <= '0;
            if (!pd_q) start_o <= 1'b1;
            st <= S_CONV;
          end else if (tmo_hit) begin
            err_o   <= 1'b1;
            start_o <= 1'b0;
            st      <= S_IDLE;
          end else begin
            tmo_cnt <= tmo_cnt + 1'b1;
          end
        end
        S_CONV: begin
          if (!busy_s) begin
            cs_n_o <= 1'b0;
            st     <= S_SEL;
          end else if (tmo_hit) begin
            err_o   <= 1'b1;
            start_o <= 1'b0;
            st      <= S_IDLE;
          end else begin
            tmo_cnt <= tmo_cnt + 1'b1;
          end
        end
        S_SEL: begin
          rd_n_o <= 1'b0;
          st     <= S_READ;
        end
        S_READ: begin
          if (ph_zero) begin
            rd_n_o     <= 1'b1;
            data_o     <= rd_data_i;
            data_vld_o <= 1'b1;
            st         <= S_HOLD;
          end
        end
        S_HOLD: begin
          cs_n_o <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adch_host.sv
module adch_host #(
  parameter int DATA_W      = 8,
  parameter int TMO_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int START_W_CYC = 2,
  parameter int PWRUP_CYC   = 50,
  parameter int RD_LOW_CYC  = 2,
  parameter int GUARD_CYC   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_i,
  input  logic              pd_mode_i,
  input  logic [TMO_W-1:0]  tmo_limit_i,
  output logic              cnv_start_o,
  input  logic              cnv_busy_i,
  output logic              cs_n_o,
  output logic              rd_n_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_vld_o,
  output logic              err_o
);
  localparam int PH_MAX0 = (PWRUP_CYC > START_W_CYC) ? PWRUP_CYC : START_W_CYC;
  localparam int PH_MAX  = (PH_MAX0 > RD_LOW_CYC) ? PH_MAX0 : RD_LOW_CYC;
  localparam int PH_W    = $clog2(PH_MAX + 1);
  localparam int GD_W    = $clog2(GUARD_CYC + 1);

  logic            busy_s;
  logic            ph_load, ph_zero, gd_load, gd_zero;
  logic [PH_W-1:0] ph_val;
  logic [GD_W-1:0] gd_val;

  adch_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(cnv_busy_i), .q(busy_s)
  );

  adch_timer #(.W(PH_W)) u_phase (
    .clk(clk), .rst(rst), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
  );

  adch_timer #(.W(GD_W)) u_guard (
    .clk(clk), .rst(rst), .load(gd_load), .load_val(gd_val), .zero(gd_zero)
  );

  adch_seq #(
    .DATA_W(DATA_W), .TMO_W(TMO_W), .PH_W(PH_W), .GD_W(GD_W),
    .START_W_CYC(START_W_CYC), .PWRUP_CYC(PWRUP_CYC),
    .RD_LOW_CYC(RD_LOW_CYC), .GUARD_CYC(GUARD_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .trig_i(trig_i), .pd_mode_i(pd_mode_i),
    .tmo_limit_i(tmo_limit_i), .busy_s(busy_s), .rd_data_i(rd_data_i),
    .ph_zero(ph_zero), .gd_zero(gd_zero),
    .ph_load(ph_load), .ph_val(ph_val), .gd_load(gd_load), .gd_val(gd_val),
    .start_o(cnv_start_o), .cs_n_o(cs_n_o), .rd_n_o(rd_n_o),
    .data_o(data_o), .data_vld_o(data_vld_o), .err_o(err_o)
  );
endmodule

// File: rtl/adch_checker.sv
module adch_checker #(
  parameter int START_W_CYC = 2,
  parameter int GUARD_CYC   = 5
) (
  input logic clk,
  input logic rst,
  input logic cnv_start_o,
  input logic cs_n_o,
  input logic rd_n_o,
  input logic data_vld_o,
  input logic err_o
);
  int   hi_cnt;
  int   gd_cnt;
  logic rd_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt  <= 0;
      gd_cnt  <= GUARD_CYC;
      rd_prev <= 1'b1;
    end else begin
      rd_prev <= rd_n_o;
      if (cnv_start_o) hi_cnt <= (hi_cnt < START_W_CYC) ? hi_cnt + 1 : hi_cnt;
      else             hi_cnt <= 0;
      if (rd_n_o && !rd_prev)   gd_cnt <= 1;
      else if (gd_cnt < GUARD_CYC) gd_cnt <= gd_cnt + 1;
    end
  end

  assert_start_width_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(cnv_start_o) |-> hi_cnt >= START_W_CYC);

  assert_rd_inside_cs_R4: assert property (@(posedge clk) disable iff (rst)
    !rd_n_o |-> !cs_n_o);

  assert_cs_hold_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n_o) |-> $past(rd_n_o));

  assert_vld_single_R5: assert property (@(posedge clk) disable iff (rst)
    data_vld_o |=> !data_vld_o);

  assert_guard_gap_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(cnv_start_o) |-> gd_cnt >= GUARD_CYC);

  assert_err_safe_R8: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (!cnv_start_o && cs_n_o && rd_n_o));
endmodule

bind adch_host adch_checker #(
  .START_W_CYC(START_W_CYC), .GUARD_CYC(GUARD_CYC)
) u_chk (
  .clk(clk), .rst(rst), .cnv_start_o(cnv_start_o), .cs_n_o(cs_n_o),
  .rd_n_o(rd_n_o), .data_vld_o(data_vld_o), .err_o(err_o)
);

// File: tb/adch_host_test.sv
`timescale 1ns/1ps
module adch_host_test;
  localparam int START_W = 2;
  localparam int PWRUP   = 50;
  localparam int RD_LOW  = 2;
  localparam int GUARD   = 5;
  localparam int PULSE   = 50;
  localparam int CONV    = 20;
  localparam int TMO     = 120;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig = 1'b0, pd_mode = 1'b0;
  logic [15:0] tmo_limit = 16'(TMO);
  logic cnv_start, cs_n, rd_n, data_vld, err;
  logic busy = 1'b0;
  logic [7:0] rd_data, data;

  always #10 clk = ~clk;

  adch_host #(.START_W_CYC(START_W), .PWRUP_CYC(PWRUP), .RD_LOW_CYC(RD_LOW),
              .GUARD_CYC(GUARD)) uut (
    .clk(clk), .rst(rst), .trig_i(trig), .pd_mode_i(pd_mode),
    .tmo_limit_i(tmo_limit), .cnv_start_o(cnv_start), .cnv_busy_i(busy),
    .cs_n_o(cs_n), .rd_n_o(rd_n), .rd_data_i(rd_data), .data_o(data),
    .data_vld_o(data_vld), .err_o(err)
  );

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural converter
  int   pulse_cnt = 0, conv_cnt = 0;
  logic st_prev = 1'b0, gated_prev = 1'b0, gated;
  logic [7:0] out_reg = 8'h00, sample = 8'h3C;
  bit   no_rise = 0, stuck = 0, quiet = 0, cur_pd = 0;
  logic [7:0] exp_q[$];

  assign rd_data = (!cs_n && !rd_n) ? out_reg : 8'h00;

  always @(posedge clk) begin
    if (rst) begin
      pulse_cnt <= 0; conv_cnt <= 0; busy <= 1'b0;
      st_prev <= 1'b0; gated_prev <= 1'b0;
    end else begin
      st_prev <= cnv_start;
      if (cnv_start && !st_prev) pulse_cnt <= PULSE;
      else if (pulse_cnt > 0)    pulse_cnt <= pulse_cnt - 1;
      gated = cnv_start || (pulse_cnt > 0);
      gated_prev <= gated;
      if (!busy) begin
        if (gated_prev && !gated && !no_rise) begin
          busy <= 1'b1;
          conv_cnt <= CONV;
        end
      end else if (!stuck) begin
        if (conv_cnt <= 1) begin
          busy <= 1'b0;
          if (!quiet) begin
            out_reg <= sample;
            exp_q.push_back(sample);
            // R2 low-power: start low at end of conversion; R3 fast: start high
            chk(cnv_start == !cur_pd, cur_pd ? "R2 start level at BUSY fall" : "R3 start level at BUSY fall",
                int'(cnv_start), int'(!cur_pd));
          end
          sample <= sample * 8'd5 + 8'd37;
        end else begin
          conv_cnt <= conv_cnt - 1;
        end
      end
    end
  end

  // port monitor
  int hi_len = 0, since_rd = 1000, start_falls = 0, vld_cnt = 0;
  logic p_start = 1'b0, p_rd = 1'b1, p_cs = 1'b1, p_vld = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (since_rd < 1000) since_rd++;
      if (rd_n && !p_rd) since_rd = 0;
      if (p_start && !cnv_start) begin
        start_falls++;
        chk(hi_len >= (cur_pd ? PWRUP : START_W), cur_pd ? "R2 power-up hold" : "R1 start width",
            hi_len, cur_pd ? PWRUP : START_W);
        chk(since_rd >= GUARD, "R6 guard after read", since_rd, GUARD);
      end
      hi_len = cnv_start ? hi_len + 1 : 0;
      if (p_rd && !rd_n)
        chk(!p_cs && !busy, "R4 read after BUSY low inside select", int'(p_cs), 0);
      if (cs_n && !p_cs)
        chk(p_rd, "R4 select held past read", int'(p_rd), 1);
      if (p_vld) chk(!data_vld, "R5 valid one cycle", int'(data_vld), 0);
      if (data_vld) begin
        vld_cnt++;
        chk(rd_n, "R5 valid with read release", int'(rd_n), 1);
        if (exp_q.size() > 0) begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(data == e, "R5 captured byte", int'(data), int'(e));
        end else chk(0, "R5 unexpected byte", int'(data), -1);
      end
      p_start = cnv_start; p_rd = rd_n; p_cs = cs_n; p_vld = data_vld;
    end
  end

  task automatic txn(input bit pd, input int gap, output bit got_vld, output bit got_err, output int cyc);
    @(negedge clk);
    cur_pd = pd; pd_mode = pd; trig = 1'b1;
    @(negedge clk);
    trig = 1'b0; cyc = 1; got_vld = 0; got_err = 0;
    while (!got_vld && !got_err && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (data_vld) got_vld = 1;
      if (err) got_err = 1;
    end
    repeat (gap) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    bit v, e;
    int c, v0, f0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!cnv_start, "R10 start low", int'(cnv_start), 0);
    chk(cs_n, "R10 cs high", int'(cs_n), 1);
    chk(rd_n, "R10 rd high", int'(rd_n), 1);
    chk(!data_vld, "R10 valid low", int'(data_vld), 0);
    chk(!err, "R10 err low", int'(err), 0);

    // low-power transactions
    repeat (2) begin
      txn(1'b1, 4, v, e, c);
      chk(v && !e, "R2 low-power transaction completes", int'(v), 1);
      chk(!cnv_start, "R2 start low after low-power read", int'(cnv_start), 0);
    end

    // fast transactions back to back, guard sets the start fall
    for (int i = 0; i < 3; i++) begin
      txn(1'b0, 0, v, e, c);
      chk(v && !e, "R3 fast transaction completes", int'(v), 1);
    end
    repeat (4) @(negedge clk);
    chk(cnv_start, "R3 start high in idle after fast mode", int'(cnv_start), 1);

    // fast to low-power switch
    txn(1'b1, 4, v, e, c);
    chk(v && !e, "R2 switch back to low-power", int'(v), 1);

    // R7: triggers while busy are ignored, including their mode
    v0 = vld_cnt; f0 = start_falls;
    @(negedge clk);
    cur_pd = 1'b1; pd_mode = 1'b1; trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    repeat (20) @(negedge clk);
    pd_mode = 1'b0; trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    repeat (45) @(negedge clk);
    trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    repeat (200) @(negedge clk);
    chk(vld_cnt - v0 == 1, "R7 one byte per accepted trigger", vld_cnt - v0, 1);
    chk(start_falls - f0 == 1, "R7 one start fall per accepted trigger", start_falls - f0, 1);

    // R8: BUSY never rises
    no_rise = 1;
    v0 = vld_cnt;
    txn(1'b1, 2, v, e, c);
    chk(e, "R8 timeout on BUSY rise flagged", int'(e), 1);
    chk(c >= TMO && c <= TMO + PWRUP + 20, "R8 timeout latency", c, TMO);
    chk(!cnv_start && cs_n && rd_n, "R8 lines idle after timeout", int'(cnv_start), 0);
    chk(vld_cnt == v0, "R8 no byte", vld_cnt - v0, 0);
    no_rise = 0;
    repeat (10) @(negedge clk);

    // R9: BUSY never falls
    stuck = 1; quiet = 1;
    v0 = vld_cnt;
    txn(1'b0, 2, v, e, c);
    chk(e, "R9 timeout on BUSY fall flagged", int'(e), 1);
    chk(!cnv_start, "R9 start driven low", int'(cnv_start), 0);
    chk(vld_cnt == v0, "R9 no byte", vld_cnt - v0, 0);
    stuck = 0;
    repeat (40) @(negedge clk);
    exp_q.delete();
    quiet = 0;

    // recovery
    txn(1'b1, 4, v, e, c);
    chk(v && !e, "R9 recovery transaction completes", int'(v), 1);
    txn(1'b0, 4, v, e, c);
    chk(v && !e, "R3 fast transaction after recovery", int'(v), 1);
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule